// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block guards a brushless motor against a stalled rotor. While the start command is active and the speed loop reports that the motor is out of lock, a digital accumulator counts up, standing in for an external timing capacitor being charged. When the accumulator reaches its programmed trip level, a fault is latched and the low-side drivers are meant to be switched off by the consumer of `fault_o`.

The fault stays latched while the motor remains commanded to run, even if lock is regained. Only a stop command or reset removes it. During stop the accumulator drains at a faster rate than it charges (about 22:1 at the default prescaler settings). A short stop therefore leaves a residual count, and after a restart the trip comes sooner. A disable strap holds the accumulator at zero, so the protection can never trip.

Charge and drain step sizes come from two clock prescalers. With a system clock in the tens of MHz, a charge divider and trip level can be chosen to give a nominal trip time of about 3.3 s. The defaults are kept small so that the behaviour is easy to observe.

Top module: `stall_guard_timer`

## Requirements
- R1: After reset `level_o` is 0 and `fault_o` is 0.
- R2: While `run_i`=1, `lock_i`=0 and `guard_off_i`=0, `level_o` rises by exactly one every CHG_DIV clock cycles. The first step comes CHG_DIV cycles after charging begins.
- R3: `level_o` saturates at TRIP_LEVEL and never exceeds it.
- R4: `fault_o` rises one cycle after `level_o` first equals TRIP_LEVEL while `run_i`=1 and `guard_off_i`=0.
- R5: Once set, `fault_o` stays 1 for as long as `run_i`=1, including while `lock_i`=1.
- R6: `fault_o` clears on the first clock edge with `run_i`=0.
- R7: While `run_i`=0, `level_o` falls by one every DRN_DIV cycles, starting with the first edge of the stop, and stays at 0 once it gets there.
- R8: After a partial drain, restarting charges from the residual level. The trip therefore follows after (TRIP_LEVEL − residual) × CHG_DIV cycles.
- R9: While `run_i`=1 and `lock_i`=1, `level_o` holds. Any partial charge interval is discarded, so the next step needs a full CHG_DIV cycles of unlock.
- R10: While `guard_off_i`=1, `level_o` is forced to 0 on the next edge and `fault_o` cannot become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start command, 1 = run, 0 = stop |
| lock_i | input | 1 | Speed lock flag, 1 = within lock range |
| guard_off_i | input | 1 | Disable strap, 1 = protection held off |
| fault_o | output | 1 | Latched stall fault, 1 = low-side drive off |
| level_o | output | CNT_W | Present accumulator value |

## Verification
A corrupted prescaler count appears at `level_o` as a step arriving one or more cycles early or late. It is therefore caught within one charge or drain interval by checks placed on the exact step cycle. A wrong accumulator value shows directly on `level_o` at the next sample. It also shifts the trip cycle, which the trip and residual scenarios pin down to a single cycle. A fault latch that clears early, or fails to clear on stop, is seen on `fault_o` within one cycle of the lock change or stop.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_CHARGE = 2'd1,
    ACT_DRAIN  = 2'd2,
    ACT_CLEAR  = 2'd3
  } level_act_e;
endpackage

// File: rtl/stall_tick_gen.sv
module stall_tick_gen #(
  parameter int unsigned DIV = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  // count restarts whenever enable drops: partial intervals are discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/stall_level_acc.sv
module stall_level_acc
  import stall_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned TRIP_LEVEL = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  level_act_e       act_i,
  output logic [CNT_W-1:0] level_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] TRIP = CNT_W'(TRIP_LEVEL);

  logic [CNT_W-1:0] level_q, level_d;

  always_comb begin
    level_d = level_q;
    unique case (act_i)
      ACT_CLEAR:  level_d = '0;
      ACT_CHARGE: if (level_q < TRIP) level_d = level_q + 1'b1;
      ACT_DRAIN:  if (level_q != '0)  level_d = level_q - 1'b1;
      default:    level_d = level_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  assign level_o    = level_q;
  assign at_limit_o = (level_q == TRIP);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= TRIP);
  assert_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == '0 && act_i == ACT_DRAIN) |=> level_q == '0);
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_CLEAR |=> level_q == '0);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_HOLD |=> $stable(level_q));
endmodule

// File: rtl/stall_fault_latch.sv
module stall_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic guard_off_i,
  input  logic at_limit_i,
  output logic fault_o
);
  logic fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         fault_q <= 1'b0;
    else if (!run_i)                     fault_q <= 1'b0;
    else if (at_limit_i && !guard_off_i) fault_q <= 1'b1;
  end

  assign fault_o = fault_q;

  assert_latched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && run_i) |=> fault_q);
  assert_stop_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !fault_q);
  assert_guard_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guard_off_i && !fault_q) |=> !fault_q);
  assert_set_at_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(at_limit_i));
endmodule

// File: rtl/stall_guard_timer.sv
module stall_guard_timer
  import stall_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned TRIP_LEVEL = 100,
  parameter int unsigned CHG_DIV    = 22,
  parameter int unsigned DRN_DIV    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             lock_i,
  input  logic             guard_off_i,
  output logic             fault_o,
  output logic [CNT_W-1:0] level_o
);
  logic chg_en, drn_en, chg_tick, drn_tick, at_limit;
  level_act_e act;

  assign chg_en = run_i && !lock_i && !guard_off_i;
  assign drn_en = !run_i && !guard_off_i;

  stall_tick_gen #(.DIV(CHG_DIV)) u_chg_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(chg_en), .tick_o(chg_tick));

  stall_tick_gen #(.DIV(DRN_DIV)) u_drn_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(drn_en), .tick_o(drn_tick));

  always_comb begin
    if (guard_off_i)   act = ACT_CLEAR;
    else if (chg_tick) act = ACT_CHARGE;
    else if (drn_tick) act = ACT_DRAIN;
    else               act = ACT_HOLD;
  end

  stall_level_acc #(.CNT_W(CNT_W), .TRIP_LEVEL(TRIP_LEVEL)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act),
    .level_o(level_o), .at_limit_o(at_limit));

  stall_fault_latch u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .guard_off_i(guard_off_i),
    .at_limit_i(at_limit), .fault_o(fault_o));

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !guard_off_i) |=> (level_o == $past(level_o) ||
                                 level_o == $past(level_o) + 1'b1));
  assert_locked_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && lock_i && !guard_off_i) |=> $stable(level_o));
endmodule

// File: tb/stall_guard_timer_tb.sv
module stall_guard_timer_tb;
  localparam int CNT_W = 8;
  localparam int TRIP  = 100;
  localparam int CDIV  = 22;
  localparam int DDIV  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, lock = 1'b0, guard = 1'b0;
  logic fault;
  logic [CNT_W-1:0] level;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  stall_guard_timer #(.CNT_W(CNT_W), .TRIP_LEVEL(TRIP), .CHG_DIV(CDIV),
                      .DRN_DIV(DDIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .lock_i(lock),
    .guard_off_i(guard), .fault_o(fault), .level_o(level));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 level", level, 0);
    chk("R1 fault", fault, 0);
  endtask

  task automatic t_charge;
    run = 1; lock = 0;
    step(CDIV - 1); chk("R2 before first step", level, 0);
    step(1);        chk("R2 first step", level, 1);
    step(CDIV * 4); chk("R2 five steps", level, 5);
  endtask

  task automatic t_lock_hold;
    step(5); lock = 1;
    step(100);      chk("R9 hold while locked", level, 5);
    lock = 0;
    step(CDIV - 1); chk("R9 partial interval discarded", level, 5);
    step(1);        chk("R9 step after full interval", level, 6);
  endtask

  task automatic t_trip;
    step((TRIP - 6) * CDIV - 1);
    chk("R4 level one below", level, TRIP - 1);
    chk("R4 no early fault", fault, 0);
    step(1); chk("R3 reaches limit", level, TRIP);
    chk("R4 fault one cycle later", fault, 0);
    step(1); chk("R4 fault set", fault, 1);
    step(50); chk("R3 saturated", level, TRIP);
    lock = 1;
    step(30); chk("R5 fault held after relock", fault, 1);
  endtask

  task automatic t_stop_drain;
    run = 0; lock = 0;
    step(1);  chk("R6 stop clears fault", fault, 0);
    chk("R7 first drain step", level, TRIP - 1);
    step(39); chk("R7 drained 40", level, TRIP - 40);
  endtask

  task automatic t_residual;
    run = 1;
    step(40 * CDIV); chk("R8 back at limit", level, TRIP);
    chk("R8 fault not yet", fault, 0);
    step(1); chk("R8 early trip", fault, 1);
  endtask

  task automatic t_floor;
    run = 0;
    step(TRIP + 50); chk("R7 floor level", level, 0);
    chk("R6 fault after long stop", fault, 0);
  endtask

  task automatic t_guard;
    run = 1; lock = 0; guard = 1;
    step(TRIP * CDIV + 50);
    chk("R10 level held at zero", level, 0);
    chk("R10 no trip", fault, 0);
    guard = 0;
    step(10 * CDIV); chk("R10 charge resumes", level, 10);
    guard = 1;
    step(1); chk("R10 strap clears level", level, 0);
    guard = 0; run = 0;
  endtask

  initial begin
    fork
      begin
        step(3); #1 rst_n = 1; step(1);
        t_reset; t_charge; t_lock_hold; t_trip; t_stop_drain;
        t_residual; t_floor; t_guard;
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule